// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-slave SPI master that software drives through a small word-addressed register bus. A write to the transmit register starts one frame on the serial pins. Each frame is 8 or 16 bits long, as a configuration bit selects. When the frame has shifted out, the word clocked in from the slave is held in a receive register, and a completion flag is set in a cause register. Software clears that flag by writing zero to the cause register before it starts the next frame.

The serial clock is a division of the system clock. A 5-bit prescale code in the configuration register selects an even divisor between 4 and 30. Another configuration bit moves the input sample point one system clock after the rising SCK edge, which gives more hold margin. The active-low slave select is not tied to frames. It follows a control register bit, so one selection can span any number of frames.

Register word addresses: 0 configuration, 1 control, 2 transmit, 3 receive, 4 cause. Configuration fields: prescale code in bits 4:0, frame width in bit 5 (1 = 16 bits), late sample in bit 14. Control fields: select enable in bit 0, busy (read-only) in bit 1. Cause: completion flag in bit 0.

Top module: `spim_top`

## Requirements
- R1: A write to address 2 while idle starts exactly one frame. The busy bit (control bit 1) reads 1 from the cycle after that write until the cycle in which the completion flag is set. The frame lasts frame-width × divisor system clocks.
- R2: Configuration bit 5 selects the frame width. When it is 1, a frame has 16 SCK pulses. When it is 0, a frame has 8. The width is latched when the frame starts.
- R3: The completion flag (cause bit 0) is set at the end of each frame. Writing zero to address 4 clears it. Writing a nonzero value to address 4 leaves it unchanged.
- R4: Address 3 returns the received word, first bit received in the most significant position. In 8-bit frames, bits 15:8 read zero.
- R5: For prescale codes 0x12 to 0x1F, the SCK period is 2 × (code & 0xF) system clocks. Every other code gives a period of 30.
- R6: The link runs in SPI mode 0. SCK idles low. MOSI presents the MSB first (bit 15 or bit 7) and changes only on falling SCK edges. In nominal mode, MISO is sampled at the rising SCK edge.
- R7: csN is low exactly while control bit 0 is 1. Frames do not change it.
- R8: When configuration bit 14 is 1, MISO is sampled one system clock after each rising SCK edge instead of at the edge.
- R9: A write to address 2 during a frame is ignored. The running frame, its data and its length are unchanged, and no second frame follows.
- R10: After reset, configuration reads 0x32 (16-bit, code 0x12), control, cause and receive read 0, csN is high and SCK is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register word address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the addressed register (combinational) |
| sckOut | output | 1 | Serial clock to the slave |
| mosiOut | output | 1 | Serial data to the slave |
| misoIn | input | 1 | Serial data from the slave |
| csN | output | 1 | Active-low slave select |

## Verification
The properties assume that the register address and write strobe are defined on every cycle after reset. They also assume the configuration register is rewritten only while no frame is running. The bench meets both conditions: it drives every bus input on falling clock edges and changes configuration only between frames. Its slave model moves MISO one nanosecond after an SCK edge, never at the sample instant. To tell the two sample points apart, the slave can shift on rising edges, so a late sample sees the next bit while a nominal one sees the current bit.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int ADDR_CFG   = 0;
  localparam int ADDR_CTL   = 1;
  localparam int ADDR_TX    = 2;
  localparam int ADDR_RX    = 3;
  localparam int ADDR_CAUSE = 4;

  localparam int CFG_WIDE_BIT = 5;
  localparam int CFG_LATE_BIT = 14;

  localparam logic [4:0] CODE_RESET = 5'h12;

  typedef struct packed {
    logic load;    // capture transmit word, latch frame options
    logic sample;  // nominal MISO sample point (rising SCK)
    logic shift;   // falling SCK: advance shift register
    logic finish;  // last falling edge of the frame
  } spimStrobes_t;

  // Half SCK period in system clocks; illegal codes clamp to the slowest rate.
  function automatic logic [3:0] halfFromCode(input logic [4:0] code);
    if (code[4] && (code[3:0] >= 4'd2)) return code[3:0];
    return 4'd15;
  endfunction

endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int HALF_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [HALF_W-1:0] halfIn,
  input  logic              wideIn,
  output spimStrobes_t      strb,
  output logic              sckOut,
  output logic              busy
);

  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_WIDE   = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] LAST_NARROW = BIT_W'(FRAME_W / 2 - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} ctrlState_t;

  ctrlState_t        state;
  logic [HALF_W-1:0] halfCnt;
  logic [HALF_W-1:0] halfLat;
  logic [BIT_W-1:0]  bitCnt;

  always_comb begin
    strb        = '0;
    strb.load   = (state == ST_IDLE) && startReq;
    strb.sample = (state == ST_LOW) && (halfCnt == '0);
    strb.shift  = (state == ST_HIGH) && (halfCnt == '0);
    strb.finish = strb.shift && (bitCnt == '0);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      halfLat <= '0;
      bitCnt  <= '0;
      sckOut  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= ST_LOW;
            halfLat <= halfIn;
            halfCnt <= halfIn - HALF_W'(1);
            bitCnt  <= wideIn ? LAST_WIDE : LAST_NARROW;
          end
        end
        ST_LOW: begin
          if (halfCnt == '0) begin
            sckOut  <= 1'b1;
            state   <= ST_HIGH;
            halfCnt <= halfLat - HALF_W'(1);
          end else begin
            halfCnt <= halfCnt - HALF_W'(1);
          end
        end
        ST_HIGH: begin
          if (halfCnt == '0) begin
            sckOut <= 1'b0;
            if (bitCnt == '0) begin
              state <= ST_IDLE;
            end else begin
              bitCnt  <= bitCnt - BIT_W'(1);
              state   <= ST_LOW;
              halfCnt <= halfLat - HALF_W'(1);
            end
          end else begin
            halfCnt <= halfCnt - HALF_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  spimStrobes_t      strb,
  input  logic              busy,
  input  logic              misoIn,
  output logic              mosiOut,
  output logic              csN,
  output logic              startReq,
  output logic [3:0]        halfOut,
  output logic              wideOut,
  output logic              doneFlag
);

  localparam int HALF_FRAME = FRAME_W / 2;

  logic [4:0]         prescaleCode;
  logic               wideMode;
  logic               lateSample;
  logic               csEnable;
  logic [FRAME_W-1:0] rxWord;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] nextShift;
  logic               misoHold;
  logic               sampleDly;
  logic               wideLat;
  logic               lateLat;
  logic               captureNow;

  logic cfgWrite, ctlWrite, causeWrite;

  assign cfgWrite   = regWrEn && (regAddr == ADDR_W'(ADDR_CFG));
  assign ctlWrite   = regWrEn && (regAddr == ADDR_W'(ADDR_CTL));
  assign causeWrite = regWrEn && (regAddr == ADDR_W'(ADDR_CAUSE));
  assign startReq   = regWrEn && (regAddr == ADDR_W'(ADDR_TX));

  assign halfOut = halfFromCode(prescaleCode);
  assign wideOut = wideMode;
  assign csN     = ~csEnable;

  assign nextShift  = {shiftReg[FRAME_W-2:0], misoHold};
  assign captureNow = lateLat ? sampleDly : strb.sample;

  // MOSI tap depends on latched frame width.
  generate
    if (FRAME_W > 1) begin : g_tap
      assign mosiOut = wideLat ? shiftReg[FRAME_W-1] : shiftReg[HALF_FRAME-1];
    end
  endgenerate

  // Configuration, control and cause registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescaleCode <= CODE_RESET;
      wideMode     <= 1'b1;
      lateSample   <= 1'b0;
      csEnable     <= 1'b0;
      doneFlag     <= 1'b0;
    end else begin
      if (cfgWrite) begin
        prescaleCode <= regWrData[4:0];
        wideMode     <= regWrData[CFG_WIDE_BIT];
        lateSample   <= regWrData[CFG_LATE_BIT];
      end
      if (ctlWrite) csEnable <= regWrData[0];
      if (strb.finish) doneFlag <= 1'b1;
      else if (causeWrite && (regWrData == '0)) doneFlag <= 1'b0;
    end
  end

  // Shift path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rxWord    <= '0;
      misoHold  <= 1'b0;
      sampleDly <= 1'b0;
      wideLat   <= 1'b1;
      lateLat   <= 1'b0;
    end else begin
      sampleDly <= strb.sample;
      if (captureNow) misoHold <= misoIn;
      if (strb.load) begin
        shiftReg <= regWrData[FRAME_W-1:0];
        wideLat  <= wideMode;
        lateLat  <= lateSample;
      end else if (strb.shift) begin
        shiftReg <= nextShift;
      end
      if (strb.finish) begin
        rxWord <= wideLat ? nextShift
                          : {{HALF_FRAME{1'b0}}, nextShift[HALF_FRAME-1:0]};
      end
    end
  end

  // Read mux
  always_comb begin
    regRdData = '0;
    unique case (int'(regAddr))
      ADDR_CFG: begin
        regRdData[4:0]          = prescaleCode;
        regRdData[CFG_WIDE_BIT] = wideMode;
        regRdData[CFG_LATE_BIT] = lateSample;
      end
      ADDR_CTL: begin
        regRdData[0] = csEnable;
        regRdData[1] = busy;
      end
      ADDR_RX:    regRdData[FRAME_W-1:0] = rxWord;
      ADDR_CAUSE: regRdData[0] = doneFlag;
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  output logic              csN
);

  spimStrobes_t strbW;
  logic         busyW;
  logic         startW;
  logic [3:0]   halfW;
  logic         wideW;
  logic         doneFlagW;

  spim_ctrl #(
    .FRAME_W(FRAME_W),
    .HALF_W (4)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startW),
    .halfIn  (halfW),
    .wideIn  (wideW),
    .strb    (strbW),
    .sckOut  (sckOut),
    .busy    (busyW)
  );

  spim_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .strb     (strbW),
    .busy     (busyW),
    .misoIn   (misoIn),
    .mosiOut  (mosiOut),
    .csN      (csN),
    .startReq (startW),
    .halfOut  (halfW),
    .wideOut  (wideW),
    .doneFlag (doneFlagW)
  );

endmodule

// File: rtl/spim_chk.sv
module spim_chk
  import spim_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic              sckOut,
  input logic              csN,
  input logic              busy,
  input logic              doneFlag
);

  logic txWr, ctlWr;
  assign txWr  = regWrEn && (regAddr == ADDR_W'(ADDR_TX));
  assign ctlWr = regWrEn && (regAddr == ADDR_W'(ADDR_CTL));

  // R6: SCK rests low whenever no frame is running
  a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sckOut);

  // R1: a transmit write while idle starts a frame
  a_r1_start_frame: assert property (@(posedge clk) disable iff (!rstN)
    (txWr && !busy) |=> busy);

  // R1: busy drops only together with the completion flag
  a_r1_busy_ends_flag: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneFlag);

  // R3: flag rises only at the end of a frame
  a_r3_flag_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> ($past(busy) && !busy));

  // R9: a transmit write during a frame does not disturb it
  a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (txWr && busy) |=> (busy || $rose(doneFlag)));

  // R7: select moves only on a control write
  a_r7_cs_holds: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWr |=> $stable(csN));

endmodule

bind spim_top spim_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .regAddr (regAddr),
  .regWrEn (regWrEn),
  .sckOut  (sckOut),
  .csN     (csN),
  .busy    (busyW),
  .doneFlag(doneFlagW)
);

// File: tb/spim_top_tb_top.sv
`timescale 1ns/1ps
module spim_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sckOut, mosiOut, misoIn, csN;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  spim_top dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sckOut(sckOut),
    .mosiOut(mosiOut), .misoIn(misoIn), .csN(csN)
  );

  // Slave model
  logic [15:0] slaveReg = '0;
  logic        slaveWide = 1'b1;
  logic        slaveRise = 1'b0;
  logic [15:0] mosiCap = '0;
  int          riseCnt = 0;

  assign misoIn = slaveWide ? slaveReg[15] : slaveReg[7];

  always @(posedge sckOut) begin
    mosiCap = {mosiCap[14:0], mosiOut};
    riseCnt = riseCnt + 1;
  end
  always @(posedge sckOut) if (slaveRise) begin #1 slaveReg = slaveReg << 1; end
  always @(negedge sckOut) if (!slaveRise) begin #1 slaveReg = slaveReg << 1; end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung (act=%0d exp<150000)", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regAddr = 3'(a); regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    regAddr = 3'(a);
    #1;
    v = regRdData;
  endtask

  function automatic int expDiv(input int code);
    if (code >= 18 && code <= 31) return 2 * (code - 16);
    return 30;
  endfunction

  task automatic runFrame(input int code, input bit wide, input bit late,
                          input bit rise, input logic [15:0] tx,
                          input logic [15:0] s);
    logic [31:0] v;
    int w, cnt, expCyc;
    logic [15:0] mask, expRx;
    w = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    wr(0, (32'(late) << 14) | (32'(wide) << 5) | 32'(code));
    wr(4, 32'h0);
    slaveWide = wide; slaveRise = rise; slaveReg = s;
    mosiCap = '0; riseCnt = 0;
    wr(2, {16'h0, tx});
    cnt = 0;
    forever begin
      rd(4, v);
      if (v[0] || cnt > 2000) break;
      @(negedge clk);
      cnt++;
    end
    expCyc = w * expDiv(code);
    chk(cnt == expCyc, "R5 frame length", cnt, expCyc);
    chk(riseCnt == w, "R2 sck pulses", riseCnt, w);
    chk((mosiCap & mask) == (tx & mask), "R6 mosi msb first", mosiCap & mask, tx & mask);
    expRx = ((rise && late) ? (s << 1) : s) & mask;
    rd(3, v);
    chk(v == {16'h0, expRx}, late ? "R8 late sample rx" : "R4 rx word", v, expRx);
    chk(sckOut == 1'b0, "R6 sck idle low", sckOut, 0);
  endtask

  initial begin
    logic [31:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(0, v); chk(v == 32'h32, "R10 cfg reset", v, 32'h32);
    rd(1, v); chk(v == 0, "R10 ctl reset", v, 0);
    rd(3, v); chk(v == 0, "R10 rx reset", v, 0);
    rd(4, v); chk(v == 0, "R10 cause reset", v, 0);
    chk(csN == 1'b1, "R10 csN high", csN, 1);
    chk(sckOut == 1'b0, "R10 sck low", sckOut, 0);

    // R5 sweep over every code, 8-bit frames
    for (int c = 0; c < 32; c++)
      runFrame(c, 1'b0, 1'b0, 1'b0, 16'(c * 37 + 16'h5A), 16'(~(c * 53)));

    // R2 / R4 16-bit frames at several rates
    runFrame(18, 1'b1, 1'b0, 1'b0, 16'hA55A, 16'h3C96);
    runFrame(25, 1'b1, 1'b0, 1'b0, 16'h8001, 16'hF00F);
    runFrame(31, 1'b1, 1'b0, 1'b0, 16'h1234, 16'hFEDC);

    // R8 sample point: rising-edge slave separates nominal from late
    runFrame(18, 1'b1, 1'b0, 1'b1, 16'h0F0F, 16'hB3C5);
    runFrame(18, 1'b1, 1'b1, 1'b1, 16'h0F0F, 16'hB3C5);
    runFrame(20, 1'b0, 1'b1, 1'b1, 16'h00C3, 16'h00A9);
    runFrame(22, 1'b1, 1'b1, 1'b0, 16'h7E81, 16'h6D29);

    // R3 cause write semantics
    wr(4, 32'h5);
    rd(4, v); chk(v == 1, "R3 nonzero write keeps flag", v, 1);
    wr(4, 32'h0);
    rd(4, v); chk(v == 0, "R3 zero write clears", v, 0);

    // R7 select under register control across frames
    wr(1, 32'h1);
    chk(csN == 1'b0, "R7 csN asserted", csN, 0);
    runFrame(18, 1'b0, 1'b0, 1'b0, 16'h0055, 16'h00AA);
    chk(csN == 1'b0, "R7 csN held after frame", csN, 0);
    runFrame(19, 1'b0, 1'b0, 1'b0, 16'h00AA, 16'h0055);
    chk(csN == 1'b0, "R7 csN held after 2 frames", csN, 0);
    wr(1, 32'h0);
    chk(csN == 1'b1, "R7 csN released", csN, 1);

    // R9 / R1 transmit write during a frame is ignored
    wr(0, 32'h32);
    wr(4, 32'h0);
    slaveWide = 1'b1; slaveRise = 1'b0; slaveReg = 16'hC0DE;
    mosiCap = '0; riseCnt = 0;
    wr(2, 32'h0000_9A3C);
    repeat (10) @(negedge clk);
    rd(1, v); chk(v[1] == 1'b1, "R1 busy during frame", v[1], 1);
    wr(2, 32'h0000_FFFF);
    cnt = 0;
    forever begin
      rd(4, v);
      if (v[0] || cnt > 2000) break;
      @(negedge clk);
      cnt++;
    end
    repeat (200) @(negedge clk);
    chk(riseCnt == 16, "R9 single frame", riseCnt, 16);
    chk(mosiCap == 16'h9A3C, "R9 data unchanged", mosiCap, 16'h9A3C);
    rd(3, v); chk(v == 32'hC0DE, "R9 rx unchanged", v, 32'hC0DE);
    rd(1, v); chk(v[1] == 1'b0, "R1 busy clear after frame", v[1], 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule